// File: doc/BRIEF.md
# Physical Address Cacheability Classifier

This block inspects each translated physical address before it reaches the memory system and labels it. An address is uncacheable when either of two upper marker bits is set: bit 39 (older platform convention) or bit 40 (newer platform convention). The block also flags an access to the internal-register window. This window is not implemented, and an access to it is an error unless the request was issued down a misspeculated path.

Software on one machine is expected to use only one of the two marker conventions. The block therefore remembers which convention it has seen since reset. When an access uses the other convention, it raises a conflict flag that stays set until reset.

Requests enter on a valid/ready channel, and each result leaves one cycle later on a second valid/ready channel. The output stage holds a single result. A new request is accepted only when that stage is empty or is being drained in the same cycle, so `in_ready` is `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result stays frozen and the input stalls. The conflict flag is a plain status pin and is not part of the handshake.

Top module: `pa_class_top`

## Requirements
- R1: An accepted access is tagged uncacheable (`out_uncached`=1) when address bit 39 or bit 40 is set, and cacheable otherwise.
- R2: `out_ipr_err` is 1 for an accepted access whose address is at or above 0xFFFFFF00000, that is uncacheable, and whose `in_misspec` is 0. It is 0 in every other case.
- R3: An access to the internal-register window is still tagged uncacheable. A misspeculated access to that window raises no error but is still tagged uncacheable.
- R4: An accepted access with bit 40 set sets the conflict flag if any earlier access since reset had bit 39 as its marker. The access then counts as a bit-40 access.
- R5: An accepted access with bit 39 set and bit 40 clear sets the conflict flag if any earlier access since reset had bit 40 set. The access then counts as a bit-39 access. When both bits are set, bit 40 wins.
- R6: `conflict_err` stays high from the cycle after the conflicting access until reset. Misspeculated accesses update the convention history in the same way as other accesses.
- R7: The result appears on the output one cycle after acceptance. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output fields do not change.
- R8: Synchronous active-high reset clears `out_valid`, `conflict_err` and both history bits.
- R9: A cacheable access (neither marker bit set) raises no error and does not change the convention history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | 44 | Physical address |
| in_misspec | input | 1 | Request lies on a misspeculated path |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_uncached | output | 1 | Access is uncacheable |
| out_ipr_err | output | 1 | Access hit the unimplemented register window |
| conflict_err | output | 1 | Sticky: both marker conventions have been seen |

## Verification
The register-window error and a convention conflict can both be caused by a single access. Every address in the window has bits 39 and 40 set, so a window access that follows a bit-39 access raises both flags in one result. The bench provokes this with directed sequences: a bit-39 access, then a window access, run once with and once without the misspeculation mark. Random sequences mix the same kinds of access. A bench model predicts each flag separately, and the prediction for each flag is compared in the same output cycle.

// File: rtl/pa_class_pkg.sv
package pa_class_pkg;
  typedef struct packed {
    logic uc;       // either marker bit set
    logic use_hi;   // bit 40 convention (wins when both set)
    logic use_lo;   // bit 39 convention only
    logic in_win;   // at or above register window base
  } pa_class_t;
endpackage

// File: rtl/pa_class_decode.sv
module pa_class_decode
  import pa_class_pkg::*;
#(
  parameter int          ADDR_W   = 44,
  parameter int          LO_BIT   = 39,
  parameter int          HI_BIT   = 40,
  parameter logic [43:0] WIN_BASE = 44'hFFFFFF00000
) (
  input  logic [ADDR_W-1:0] addr,
  output pa_class_t         cls
);
  localparam logic [ADDR_W-1:0] BASE = WIN_BASE[ADDR_W-1:0];

  logic hi_set, lo_set;

  always_comb begin
    hi_set     = addr[HI_BIT];
    lo_set     = addr[LO_BIT];
    cls.uc     = hi_set | lo_set;
    cls.use_hi = hi_set;
    cls.use_lo = lo_set & ~hi_set;
    cls.in_win = (addr >= BASE);
  end
endmodule

// File: rtl/pa_class_history.sv
module pa_class_history
  import pa_class_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      take,
  input  pa_class_t cls,
  output logic      conflict_err
);
  logic seen_lo, seen_hi, sticky;
  logic clash;

  always_comb begin
    clash = (cls.use_hi & seen_lo) | (cls.use_lo & seen_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_lo <= 1'b0;
      seen_hi <= 1'b0;
      sticky  <= 1'b0;
    end else if (take) begin
      if (cls.use_hi) seen_hi <= 1'b1;
      if (cls.use_lo) seen_lo <= 1'b1;
      if (clash)      sticky  <= 1'b1;
    end
  end

  assign conflict_err = sticky;
endmodule

// File: rtl/pa_class_outstage.sv
module pa_class_outstage
  import pa_class_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  input  pa_class_t cls,
  input  logic      misspec,
  input  logic      out_ready,
  output logic      in_ready,
  output logic      take,
  output logic      out_valid,
  output logic      out_uncached,
  output logic      out_ipr_err
);
  logic vld_q, uc_q, err_q;
  logic err_d;

  always_comb begin
    in_ready = ~vld_q | out_ready;
    take     = in_valid & in_ready;
    err_d    = cls.uc & cls.in_win & ~misspec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      uc_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (take) begin
      vld_q <= 1'b1;
      uc_q  <= cls.uc;
      err_q <= err_d;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid    = vld_q;
  assign out_uncached = uc_q;
  assign out_ipr_err  = err_q & vld_q;
endmodule

// File: rtl/pa_class_top.sv
module pa_class_top
  import pa_class_pkg::*;
#(
  parameter int          ADDR_W   = 44,
  parameter int          LO_BIT   = 39,
  parameter int          HI_BIT   = 40,
  parameter logic [43:0] WIN_BASE = 44'hFFFFFF00000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_misspec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_uncached,
  output logic              out_ipr_err,
  output logic              conflict_err
);
  pa_class_t cls;
  logic      take;

  pa_class_decode #(
    .ADDR_W(ADDR_W), .LO_BIT(LO_BIT), .HI_BIT(HI_BIT), .WIN_BASE(WIN_BASE)
  ) i_decode (
    .addr(in_addr),
    .cls (cls)
  );

  pa_class_outstage i_out (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .cls         (cls),
    .misspec     (in_misspec),
    .out_ready   (out_ready),
    .in_ready    (in_ready),
    .take        (take),
    .out_valid   (out_valid),
    .out_uncached(out_uncached),
    .out_ipr_err (out_ipr_err)
  );

  pa_class_history i_hist (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .cls         (cls),
    .conflict_err(conflict_err)
  );
endmodule

// File: rtl/pa_class_chk.sv
module pa_class_chk #(
  parameter int          ADDR_W   = 44,
  parameter int          LO_BIT   = 39,
  parameter int          HI_BIT   = 40,
  parameter logic [43:0] WIN_BASE = 44'hFFFFFF00000
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              in_misspec,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_uncached,
  input logic              out_ipr_err,
  input logic              conflict_err
);
  logic acc;
  assign acc = in_valid & in_ready;

  AST_UC_MARK: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid && (out_uncached == ($past(in_addr[LO_BIT]) | $past(in_addr[HI_BIT])))); // R1

  AST_WIN_ERR: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_ipr_err == ($past(in_addr >= WIN_BASE[ADDR_W-1:0])
                            && ($past(in_addr[LO_BIT]) | $past(in_addr[HI_BIT]))
                            && !$past(in_misspec))); // R2

  AST_WIN_UC: assert property (@(posedge clk) disable iff (rst)
    out_ipr_err |-> out_uncached && out_valid); // R3

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    conflict_err |=> conflict_err); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_uncached) && $stable(out_ipr_err)); // R7

  AST_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R7
endmodule

bind pa_class_top pa_class_chk #(
  .ADDR_W(ADDR_W), .LO_BIT(LO_BIT), .HI_BIT(HI_BIT), .WIN_BASE(WIN_BASE)
) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_misspec(in_misspec), .out_valid(out_valid),
  .out_ready(out_ready), .out_uncached(out_uncached),
  .out_ipr_err(out_ipr_err), .conflict_err(conflict_err)
);

// File: tb/test_pa_class_top.sv
module test_pa_class_top;
  localparam logic [43:0] BASE = 44'hFFFFFF00000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_misspec;
  logic [43:0] in_addr;
  logic        out_valid, out_ready, out_uncached, out_ipr_err, conflict_err;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  bit m_lo, m_hi, m_conf;

  always #2.5 clk = ~clk;

  pa_class_top i_pa_class_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_misspec(in_misspec), .out_valid(out_valid),
    .out_ready(out_ready), .out_uncached(out_uncached),
    .out_ipr_err(out_ipr_err), .conflict_err(conflict_err)
  );

  function automatic bit f_uc(logic [43:0] a);
    return a[39] | a[40];
  endfunction

  function automatic bit f_err(logic [43:0] a, bit ms);
    return f_uc(a) && (a >= BASE) && !ms;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_lo = 0; m_hi = 0; m_conf = 0;
    chk("R8 out_valid", out_valid, 1'b0);
    chk("R8 conflict", conflict_err, 1'b0);
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic access(logic [43:0] a, bit ms);
    bit clash;
    in_valid = 1; in_addr = a; in_misspec = ms; out_ready = 1;
    chk("R7 in_ready", in_ready, 1'b1);
    clash = (a[40] && m_lo) || (!a[40] && a[39] && m_hi);
    if (a[40]) m_hi = 1;
    else if (a[39]) m_lo = 1;
    if (clash) m_conf = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R7 out_valid", out_valid, 1'b1);
    chk("R1 uncached", out_uncached, f_uc(a));
    chk("R2 ipr_err", out_ipr_err, f_err(a, ms));
    chk("R4/R5 conflict", conflict_err, m_conf);
  endtask

  function automatic logic [43:0] rand_addr();
    logic [43:0] a;
    int k = $urandom_range(0, 4);
    a = {$urandom(), $urandom()};
    case (k)
      0: a[40:39] = 2'b00;
      1: a[40:39] = 2'b01;
      2: a[40:39] = 2'b10;
      3: a[40:39] = 2'b11;
      default: a = BASE | 44'($urandom_range(0, 20'hFFFFF));
    endcase
    return a;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst = 1; in_valid = 0; in_addr = '0; in_misspec = 0; out_ready = 1;
    do_reset();

    // R9: cacheable accesses, no history change
    access(44'h000_1234_5678, 0);
    access(44'h7FF_FFFF_FFFF & ~(44'h3 << 39), 0);
    access(44'h000_0000_0040, 1);
    // R5 then R4: bit 39 then bit 40 -> conflict
    access(44'h080_0000_1000, 0);
    chk("R9 no conflict yet", conflict_err, 1'b0);
    access(44'h100_0000_2000, 1); // misspec still updates history (R6)
    chk("R6 sticky set", conflict_err, 1'b1);
    access(44'h000_0000_0000, 0);
    chk("R6 sticky hold", conflict_err, 1'b1);

    // R3: window access, both flags in one result
    do_reset();
    access(44'h080_0000_0000, 0);
    access(BASE, 0);
    chk("R3 window uc", out_uncached, 1'b1);
    chk("R2 window err", out_ipr_err, 1'b1);
    chk("R4 conflict with window", conflict_err, 1'b1);
    do_reset();
    access(44'h080_0000_0000, 0);
    access(BASE + 44'h55, 1);
    chk("R3 misspec no err", out_ipr_err, 1'b0);
    access(BASE - 44'h1, 0); // just below window, uncacheable
    chk("R2 below window", out_ipr_err, 1'b0);

    // R4/R5 precedence: both bits counts as bit 40
    do_reset();
    access(44'h180_0000_0000, 0);
    access(44'h100_0000_0000, 0);
    chk("R5 both=hi no conflict", conflict_err, 1'b0);
    access(44'h080_0000_0000, 0);
    chk("R5 lo after hi", conflict_err, 1'b1);

    // R7 back-pressure
    do_reset();
    out_ready = 0; in_valid = 1; in_addr = 44'h080_0000_0000; in_misspec = 0;
    @(negedge clk);
    in_addr = 44'h000_0000_0001;
    chk("R7 stalled in_ready", in_ready, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 held valid", out_valid, 1'b1);
      chk("R7 held uc", out_uncached, 1'b1);
    end
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    chk("R7 drained", out_valid, 1'b0);
    m_lo = 1;

    // random phase
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 49) do_reset();
      access(rand_addr(), $urandom_range(0, 1));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule